// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block caches recent virtual-to-physical page translations for a processor's memory path. It holds a small set of entries. Each entry records a virtual page number, a physical frame number, an address-space identifier and a valid flag. On a lookup, the upper bits of the logical address are compared against every live entry at once, together with the identifier of the requesting process. A matching entry supplies the frame number, and the low offset bits are appended to it unchanged. When nothing matches, the block reports a miss. An outside walker then fetches the translation and writes it back through the fill port.

Because every entry carries an address-space tag, translations that belong to different processes can share the buffer. A context switch therefore does not need a flush. Stale state is removed in one of two ways: a full flush clears every entry, and a tagged flush clears only the entries of one identifier. The buffer chooses where a fill goes. It reuses an entry that already holds the same page and identifier. Failing that, it takes a free slot. Failing that, it evicts the slot named by a rotating pointer.

Top module: `asid_tlb`

## Requirements
- R1: After synchronous active-low reset, all entries are invalid, the replacement pointer is 0, and rsp_valid, rsp_hit, rsp_miss and rsp_paddr are 0. A lookup made straight after reset misses.
- R2: A lookup presented while lk_req is 1 is answered on the clock edge that samples it. rsp_valid is 1 in the following cycle exactly when lk_req was 1 in the cycle before.
- R3: A lookup hits when a valid entry holds page number lk_vaddr[31:10] and ASID lk_asid. rsp_hit is then 1, rsp_miss is 0, and rsp_paddr equals {stored frame, lk_vaddr[9:0]}.
- R4: An entry whose page number matches but whose stored ASID differs from lk_asid does not produce a hit.
- R5: On a miss, rsp_miss is 1, rsp_hit is 0 and rsp_paddr is 0. rsp_hit and rsp_miss are never 1 together.
- R6: A fill whose page and ASID are not already present goes to the lowest-index invalid slot. If every slot is valid, it overwrites the slot named by the round-robin pointer, and that pointer then advances by one, wrapping from 7 to 0. The pointer moves only on such an eviction.
- R7: A fill whose page and ASID already sit in a valid entry overwrites that entry's frame in place. As a result, no two valid entries ever match the same lookup.
- R8: flush_all clears every valid flag in one cycle. It takes priority over a tagged flush and over a fill in the same cycle, and the fill is dropped.
- R9: A tagged flush (flush_asid_en) clears only the entries whose ASID equals flush_asid. It takes priority over a fill in the same cycle, and the fill is dropped.
- R10: A lookup in the same cycle as a fill or flush is answered from the contents held before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Logical address: page number in [31:10], offset in [9:0] |
| lk_asid | input | 8 | Identifier of the requesting address space |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 22 | Page number to store |
| fill_asid | input | 8 | Identifier to store |
| fill_pfn | input | 20 | Frame number to store |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate the entries of one identifier |
| flush_asid | input | 8 | Identifier to invalidate |
| rsp_valid | output | 1 | Response present (one cycle after lk_req) |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation not found |
| rsp_paddr | output | 30 | Physical address {frame, offset}, 0 on a miss |

## Verification
Directed sequences come first. They cover a cold miss, a hit, a page that matches while its identifier does not, a ninth fill that forces an eviction, a repeated fill of a page already held, both flush kinds, and lookups that share a cycle with an update. Each of these separates one rule from its nearest wrong variant: matching on the page alone, filling without a duplicate check, using the wrong victim, or answering from the post-update contents. A seeded random phase follows. It draws pages from twelve values and identifiers from three, so hits, ASID-only mismatches and repeated evictions all occur often. Every response is compared against a bench model built from the requirements.

// File: rtl/tlb_pkg.sv
// Package: shared types for the translation buffer.
// Assumes nothing beyond IEEE 1800-2017.
package tlb_pkg;
    // How a fill picks its destination slot.
    typedef enum logic [1:0] {
        FILL_MATCH = 2'd0,   // same page and ASID already present
        FILL_FREE  = 2'd1,   // an invalid slot exists
        FILL_EVICT = 2'd2    // all slots valid, use round-robin pointer
    } fill_kind_t;
endpackage

// File: rtl/tlb_cam.sv
// Module: tlb_cam
// Compares a (page, ASID) key against every entry in parallel.
// Reports the match vector, whether any entry matched, and the
// lowest-index match. Assumes the caller keeps entries unique.
module tlb_cam #(
    parameter int N      = 8,
    parameter int VPN_W  = 22,
    parameter int ASID_W = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           ent_valid,
    input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [N-1:0][ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]       key_vpn,
    input  logic [ASID_W-1:0]      key_asid,
    output logic [N-1:0]           match,
    output logic                   any,
    output logic [IDX_W-1:0]       idx
);
    // Per-entry comparators, one per slot.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_vpn[g] == key_vpn)
                          && (ent_asid[g] == key_asid);
    end

    // Priority encode: the lowest index wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign any = |match;

    // R7: fills never create duplicates, so at most one entry matches.
    assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/tlb_victim.sv
// Module: tlb_victim
// Picks the slot a fill writes: an existing matching entry first,
// then the lowest invalid slot, then the round-robin pointer.
// Assumes rr_ptr < N.
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int N      = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     ent_valid,
    input  logic             dup_any,
    input  logic [IDX_W-1:0] dup_idx,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] slot,
    output fill_kind_t       kind
);
    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    // Find the lowest-index invalid slot.
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_idx = IDX_W'(i);
        end
        free_any = ~&ent_valid;
    end

    // Choose the destination in priority order.
    always_comb begin
        if (dup_any) begin
            slot = dup_idx;
            kind = FILL_MATCH;
        end else if (free_any) begin
            slot = free_idx;
            kind = FILL_FREE;
        end else begin
            slot = rr_ptr;
            kind = FILL_EVICT;
        end
    end
endmodule

// File: rtl/asid_tlb.sv
// Module: asid_tlb (top)
// Fully associative translation buffer tagged by address-space ID.
// Lookup is combinational; the response is registered one cycle after
// the request. Priority of updates: flush_all > flush_asid_en > fill_en.
// Assumes the walker fills only after a miss and presents one fill per cycle.
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int N      = 8,
    parameter int VPN_W  = 22,
    parameter int OFF_W  = 10,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    localparam int IDX_W = $clog2(N),
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [PA_W-1:0]   rsp_paddr
);
    logic [N-1:0]             valid_q;
    logic [N-1:0][VPN_W-1:0]  vpn_q;
    logic [N-1:0][ASID_W-1:0] asid_q;
    logic [N-1:0][PFN_W-1:0]  pfn_q;
    logic [IDX_W-1:0]         rr_q;

    logic [N-1:0]     lk_match, dup_match;
    logic             lk_any, dup_any;
    logic [IDX_W-1:0] lk_idx, dup_idx, fill_slot;
    fill_kind_t       fill_kind;
    logic             do_fill;

    // Lookup comparator bank.
    tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lookup (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
        .key_vpn(lk_vaddr[VA_W-1:OFF_W]), .key_asid(lk_asid),
        .match(lk_match), .any(lk_any), .idx(lk_idx)
    );

    // Duplicate detector for the fill key.
    tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_dup (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
        .key_vpn(fill_vpn), .key_asid(fill_asid),
        .match(dup_match), .any(dup_any), .idx(dup_idx)
    );

    // Destination slot selection.
    tlb_victim #(.N(N)) u_victim (
        .ent_valid(valid_q), .dup_any(dup_any), .dup_idx(dup_idx),
        .rr_ptr(rr_q), .slot(fill_slot), .kind(fill_kind)
    );

    assign do_fill = fill_en && !flush_all && !flush_asid_en;

    // Valid flags and replacement pointer, with flush priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (flush_all) begin
            valid_q <= '0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < N; i++) begin
                if (asid_q[i] == flush_asid) valid_q[i] <= 1'b0;
            end
        end else if (fill_en) begin
            valid_q[fill_slot] <= 1'b1;
            if (fill_kind == FILL_EVICT)
                rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // Entry payload storage; contents are qualified by valid_q.
    always_ff @(posedge clk) begin
        if (do_fill) begin
            vpn_q[fill_slot]  <= fill_vpn;
            asid_q[fill_slot] <= fill_asid;
            pfn_q[fill_slot]  <= fill_pfn;
        end
    end

    // Registered lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && lk_any;
            rsp_miss  <= lk_req && !lk_any;
            rsp_paddr <= (lk_req && lk_any)
                         ? {pfn_q[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;
        end
    end

    // R2: a request produces a response in the next cycle, and only then.
    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);
    // R5: hit and miss are exclusive; a miss carries a zero address.
    assert_hit_miss_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_miss));
    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == '0));
    // R8: a global flush leaves no valid entry.
    assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));
    // R6: an accepted fill leaves at least one valid entry.
    assert_fill_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_fill |=> (valid_q != '0));
endmodule

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req;
    logic [31:0] lk_vaddr;
    logic [7:0]  lk_asid;
    logic        fill_en;
    logic [21:0] fill_vpn;
    logic [7:0]  fill_asid;
    logic [19:0] fill_pfn;
    logic        flush_all;
    logic        flush_asid_en;
    logic [7:0]  flush_asid;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [29:0] rsp_paddr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Bench model of the entries.
    bit        m_valid [N];
    bit [21:0] m_vpn   [N];
    bit [7:0]  m_asid  [N];
    bit [19:0] m_pfn   [N];
    int        m_rr;

    always #2.5 clk = ~clk;

    asid_tlb uut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_asid(fill_asid), .fill_pfn(fill_pfn), .flush_all(flush_all),
        .flush_asid_en(flush_asid_en), .flush_asid(flush_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_paddr(rsp_paddr)
    );

    function automatic void m_reset();
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        m_rr = 0;
    endfunction

    function automatic bit m_find(input bit [21:0] vpn, input bit [7:0] asid,
                                  output int slot);
        slot = 0;
        for (int i = N - 1; i >= 0; i--)
            if (m_valid[i] && m_vpn[i] == vpn && m_asid[i] == asid) begin
                slot = i;
                return 1'b1;
            end
        return 1'b0;
    endfunction

    function automatic void m_fill(input bit [21:0] vpn, input bit [7:0] asid,
                                   input bit [19:0] pfn);
        int s;
        if (!m_find(vpn, asid, s)) begin
            s = -1;
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) s = i;
            if (s < 0) begin
                s = m_rr;
                m_rr = (m_rr + 1) % N;
            end
        end
        m_valid[s] = 1'b1;
        m_vpn[s]   = vpn;
        m_asid[s]  = asid;
        m_pfn[s]   = pfn;
    endfunction

    task automatic check(input string tag, input logic [31:0] got,
                         input logic [31:0] exp, input string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // One cycle: drive, predict from old contents, update model, compare.
    task automatic step(input bit lr, input bit [31:0] va, input bit [7:0] la,
                        input bit fe, input bit [21:0] fv, input bit [7:0] fa,
                        input bit [19:0] fp, input bit fl, input bit fae,
                        input bit [7:0] fas, input string tag);
        int  s;
        bit  hit;
        bit [29:0] epa;
        @(negedge clk);
        lk_req = lr; lk_vaddr = va; lk_asid = la;
        fill_en = fe; fill_vpn = fv; fill_asid = fa; fill_pfn = fp;
        flush_all = fl; flush_asid_en = fae; flush_asid = fas;
        hit = lr && m_find(va[31:10], la, s);
        epa = hit ? {m_pfn[s], va[9:0]} : 30'd0;
        if (fl) m_reset_valid();
        else if (fae) begin
            for (int i = 0; i < N; i++) if (m_asid[i] == fas) m_valid[i] = 1'b0;
        end else if (fe) m_fill(fv, fa, fp);
        @(posedge clk);
        #1;
        check(tag, 32'(rsp_valid), 32'(lr), "rsp_valid");
        check(tag, 32'(rsp_hit), 32'(hit), "rsp_hit");
        check(tag, 32'(rsp_miss), 32'(lr && !hit), "rsp_miss");
        check(tag, 32'(rsp_paddr), 32'(epa), "rsp_paddr");
    endtask

    function automatic void m_reset_valid();
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    endfunction

    task automatic look(input bit [31:0] va, input bit [7:0] la, input string tag);
        step(1, va, la, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(input bit [21:0] v, input bit [7:0] a, input bit [19:0] p,
                        input string tag);
        step(0, 0, 0, 1, v, a, p, 0, 0, 0, tag);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1F2E3D4C;
        void'($urandom(seed));
        rst_n = 1'b0;
        lk_req = 0; lk_vaddr = 0; lk_asid = 0; fill_en = 0; fill_vpn = 0;
        fill_asid = 0; fill_pfn = 0; flush_all = 0; flush_asid_en = 0; flush_asid = 0;
        m_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs cleared in reset.
        check("R1", 32'({rsp_valid, rsp_hit, rsp_miss}), 32'd0, "flags");
        check("R1", 32'(rsp_paddr), 32'd0, "rsp_paddr");
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");
        look({22'h00ABC, 10'h155}, 8'h01, "R1 cold miss");

        // R3: fill then hit, offset passes through.
        fill(22'h00ABC, 8'h01, 20'h12345, "R6 free slot");
        look({22'h00ABC, 10'h155}, 8'h01, "R3 hit");
        look({22'h00ABC, 10'h3FF}, 8'h01, "R3 offset");
        // R4: page matches but ASID differs.
        look({22'h00ABC, 10'h001}, 8'h02, "R4 asid mismatch");
        look({22'h00ABD, 10'h001}, 8'h01, "R5 page miss");
        // R7: refill same key updates in place.
        fill(22'h00ABC, 8'h01, 20'h0BEEF, "R7 dup fill");
        look({22'h00ABC, 10'h020}, 8'h01, "R7 updated frame");
        // R6: fill to full, then evictions via the rotating pointer.
        for (int i = 1; i < 11; i++)
            fill(22'h100 + 22'(i), 8'h03, 20'h500 + 20'(i), "R6 fill/evict");
        for (int i = 0; i < 11; i++)
            look({22'h100 + 22'(i), 10'h00F}, 8'h03, "R6 residency");
        look({22'h00ABC, 10'h020}, 8'h01, "R6 evicted slot0");
        // R10: lookup sees contents before a same-cycle fill.
        step(1, {22'h2222, 10'h5}, 8'h04, 1, 22'h2222, 8'h04, 20'hCAFE, 0, 0, 0, "R10 fill");
        look({22'h2222, 10'h5}, 8'h04, "R10 after fill");
        // R9: tagged flush clears only ASID 3; fill in same cycle dropped.
        step(1, {22'h105, 10'h1}, 8'h03, 1, 22'h3333, 8'h04, 20'h1, 0, 1, 8'h03, "R9 R10 flush");
        look({22'h105, 10'h1}, 8'h03, "R9 cleared");
        look({22'h2222, 10'h6}, 8'h04, "R9 kept");
        look({22'h3333, 10'h6}, 8'h04, "R9 fill dropped");
        // R8: global flush wins over fill.
        step(0, 0, 0, 1, 22'h4444, 8'h05, 20'h2, 1, 0, 0, "R8 flush");
        look({22'h2222, 10'h6}, 8'h04, "R8 cleared");
        look({22'h4444, 10'h6}, 8'h05, "R8 fill dropped");

        // Random phase: small page/ASID pools for frequent hits and evictions.
        for (int n = 0; n < 4000; n++) begin
            int op;
            bit [21:0] v;
            bit [7:0]  a;
            op = $urandom_range(0, 99);
            v  = 22'h300 + 22'($urandom_range(0, 11));
            a  = 8'($urandom_range(1, 3));
            step(op < 60, {v, 10'($urandom)}, a,
                 op >= 40 && op < 95, 22'h300 + 22'($urandom_range(0, 11)),
                 8'($urandom_range(1, 3)), 20'($urandom),
                 op >= 98, op == 95 || op == 96, 8'($urandom_range(1, 3)),
                 "R3/R4/R5/R6 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule